// File: doc/BRIEF.md
# Granularity-Hint Translation Buffer

This block is a small, fully associative translation buffer. Each slot holds a virtual page tag, the address space number it was loaded under, a page frame number, a protection field, a global flag and a two-bit granularity hint. A lookup compares the presented page number against every slot in parallel and returns the frame and protection of the matching slot in the same cycle. A hint widens a slot so that it covers a naturally aligned run of 8, 64 or 512 pages instead of one.

Software-side maintenance comes through single-cycle command pulses: a load from a page table entry, a read-back of the slot under the replacement pointer, an address space switch, and three kinds of invalidation (full flush, flush of non-global slots, and removal of one matching slot). The replacement pointer always names the slot after the one most recently hit, loaded or read, so the next load avoids the slot in use. The same module serves as the instruction or the data buffer; `inv_en` lets a shared invalidate command reach one instance, the other, or both.

When several commands arrive in one cycle, the pointer obeys full flush, then load, then read-back, then lookup hit. Slot contents obey full flush, then non-global flush, then load followed by single invalidation, so a single invalidation that hits the slot being loaded wins.

Top module: `gh_tlb`

## Requirements
- R1: After a synchronous active-low reset, no lookup hits, the replacement pointer is 0 and `rd_pte` reads 0.
- R2: A slot hits when it is valid, its stored number equals the current address space number or its global flag is set, and `lk_vpn` XOR the slot tag is zero in every bit outside the slot's granularity mask. On a miss `lk_pfn` and `lk_prot` are 0.
- R3: The granularity mask of hint g is (1 << 3*g) - 1, so hint 1 ignores the low 3 tag bits and hint 2 the low 6.
- R4: When more than one slot matches, the lowest-index slot supplies `lk_pfn` and `lk_prot`.
- R5: A cycle with `lk_req` high and a hit sets the pointer to the hit index plus one, wrapping to 0 after the last slot; a miss leaves the pointer unchanged.
- R6: `ld_en` writes `ld_vpn`, the fields of `ld_pte` and the current address space number into the slot under the pointer at the next edge, then advances the pointer with wraparound.
- R7: `rd_pte` shows the slot under the pointer reassembled in the load format: protection in bits [PROT_W-1:0], global at bit PROT_W, hint at [PROT_W+2:PROT_W+1], frame number from bit PROT_W+3 up; an invalid slot reads 0. `rd_en` advances the pointer.
- R8: `asn_we` loads `asn_in` as the current address space number; non-global slots then hit only under the number they were loaded with, global slots under any number.
- R9: `inv_all` with `inv_full` low clears every slot whose global flag is clear, keeps global slots and leaves the pointer unchanged.
- R10: `inv_all` with `inv_full` high clears every slot, global ones included, and sets the pointer to 0.
- R11: `inv_one` clears the lowest-index slot that `inv_vpn` matches under the rules of R2, and does nothing unless `inv_sext` is all zeros or all ones.
- R12: With `inv_en` low, `inv_all` and `inv_one` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup is a real access; a hit moves the pointer |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_pfn | output | PFN_W | Frame number of the matching slot |
| lk_prot | output | PROT_W | Protection field of the matching slot |
| ld_en | input | 1 | Load a slot at the pointer |
| ld_vpn | input | VPN_W | Tag for the load |
| ld_pte | input | PTE_W | Page table entry for the load |
| rd_en | input | 1 | Advance the pointer past the slot shown on rd_pte |
| rd_pte | output | PTE_W | Slot under the pointer in load format |
| asn_we | input | 1 | Write the current address space number |
| asn_in | input | ASN_W | New address space number |
| inv_en | input | 1 | This instance accepts invalidate commands |
| inv_all | input | 1 | Invalidate many slots |
| inv_full | input | 1 | With inv_all: include global slots and clear the pointer |
| inv_one | input | 1 | Invalidate one matching slot |
| inv_vpn | input | VPN_W | Page number for inv_one |
| inv_sext | input | SEXT_W | Upper address bits checked for sign extension |

## Verification
The bench builds the buffer with four slots, a 12-bit page number, a 4-bit address space number and a 2-bit sign-extension field. Four slots let a run of four loads wrap the pointer back to slot 0 and let a hit on the last slot exercise the wrap of the jump, while the short page number keeps hint-2 regions (64 pages) easy to place so that two slots overlap and the lowest-index rule shows. The pointer is observed only through `rd_pte`, by comparing it with the entry expected at the predicted slot.

// File: rtl/gh_tlb_pkg.sv
// Shared definitions for the granularity-hint translation buffer.
// Assumes a two-bit hint where each step multiplies the covered pages by 8.
package gh_tlb_pkg;
    localparam int GH_W    = 2;
    localparam int GH_STEP = 3;

    // Action applied to the replacement pointer at the next edge.
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_ZERO = 2'd1,
        PTR_STEP = 2'd2,
        PTR_JUMP = 2'd3
    } ptr_op_e;
endpackage

// File: rtl/gh_tlb_match.sv
// Comparator for one slot: decides whether a page number falls in the slot.
// Assumes the hint-derived mask never exceeds the tag width.
module gh_tlb_match
    import gh_tlb_pkg::*;
#(
    parameter int VPN_W = 16,
    parameter int ASN_W = 8
) (
    input  logic             valid,
    input  logic             is_glb,
    input  logic [GH_W-1:0]  gh,
    input  logic [VPN_W-1:0] tag,
    input  logic [ASN_W-1:0] ent_asn,
    input  logic [ASN_W-1:0] cur_asn,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit
);
    logic [VPN_W-1:0] ign_mask;

    // Build the low-bit ignore mask of width 3*gh.
    always_comb begin
        ign_mask = '0;
        for (int b = 0; b < VPN_W; b++) begin
            if (b < GH_STEP * int'(gh)) ign_mask[b] = 1'b1;
        end
    end

    // Hit when valid, address space agrees (or global) and high bits agree.
    always_comb begin
        hit = valid && (is_glb || (ent_asn == cur_asn))
              && (((vpn ^ tag) & ~ign_mask) == '0);
    end
endmodule

// File: rtl/gh_tlb_first.sv
// Lowest-index selector over a vector of slot hits.
// Assumes idx is meaningful only when any is high.
module gh_tlb_first #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last to write idx.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
        any = |hits;
    end
endmodule

// File: rtl/gh_tlb_ptr.sv
// Not-last-used replacement pointer with clear, step and jump actions.
// Assumes jump_idx is a valid slot index whenever op is PTR_JUMP.
module gh_tlb_ptr
    import gh_tlb_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ptr_op_e       op,
    input  logic [IW-1:0] jump_idx,
    output logic [IW-1:0] ptr
);
    logic [IW-1:0] ptr_nx, jump_nx;

    // Successor of the current pointer and of the hit slot, both wrapping.
    always_comb begin
        ptr_nx  = (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
        jump_nx = (jump_idx == IW'(N - 1)) ? '0 : jump_idx + 1'b1;
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else begin
            case (op)
                PTR_ZERO: ptr <= '0;
                PTR_STEP: ptr <= ptr_nx;
                PTR_JUMP: ptr <= jump_nx;
                default:  ptr <= ptr;
            endcase
        end
    end

    // R6
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_STEP) |=> (ptr == (($past(ptr) == IW'(N - 1)) ? '0 : $past(ptr) + 1'b1)));

    // R5
    jump_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PTR_JUMP) |=> (ptr == (($past(jump_idx) == IW'(N - 1)) ? '0 : $past(jump_idx) + 1'b1)));

    // R1
    ptr_reset_chk: assert property (@(posedge clk) !rst_n |=> (ptr == '0));
endmodule

// File: rtl/gh_tlb.sv
// Fully associative translation buffer with granularity hints, global slots
// and a not-last-used replacement pointer. Lookup is combinational; loads,
// read-back steps and invalidations act at the next clock edge.
// Assumes at most the documented priority among same-cycle commands.
module gh_tlb
    import gh_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 16,
    parameter int ASN_W   = 8,
    parameter int PFN_W   = 12,
    parameter int PROT_W  = 5,
    parameter int SEXT_W  = 4,
    parameter int PTE_W   = PROT_W + 1 + GH_W + PFN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              ld_en,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [PTE_W-1:0]  ld_pte,
    input  logic              rd_en,
    output logic [PTE_W-1:0]  rd_pte,
    input  logic              asn_we,
    input  logic [ASN_W-1:0]  asn_in,
    input  logic              inv_en,
    input  logic              inv_all,
    input  logic              inv_full,
    input  logic              inv_one,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [SEXT_W-1:0] inv_sext
);
    localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int GLB_BIT = PROT_W;
    localparam int GH_LSB  = PROT_W + 1;
    localparam int PFN_LSB = GH_LSB + GH_W;

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] glb;
    logic [GH_W-1:0]    ghv  [ENTRIES];
    logic [VPN_W-1:0]   tagv [ENTRIES];
    logic [ASN_W-1:0]   asnv [ENTRIES];
    logic [PFN_W-1:0]   pfnv [ENTRIES];
    logic [PROT_W-1:0]  protv[ENTRIES];

    logic [ASN_W-1:0]   cur_asn;
    logic [ENTRIES-1:0] lk_hits, inv_hits;
    logic [IW-1:0]      lk_idx, inv_idx, ptr;
    logic               inv_any, sext_ok;
    logic               flush_full, flush_part, kill_one;
    ptr_op_e            ptr_op;

    // Two comparators per slot: one for lookup, one for single invalidation.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        gh_tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk (
            .valid(vld[e]), .is_glb(glb[e]), .gh(ghv[e]), .tag(tagv[e]),
            .ent_asn(asnv[e]), .cur_asn(cur_asn), .vpn(lk_vpn), .hit(lk_hits[e]));
        gh_tlb_match #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_inv (
            .valid(vld[e]), .is_glb(glb[e]), .gh(ghv[e]), .tag(tagv[e]),
            .ent_asn(asnv[e]), .cur_asn(cur_asn), .vpn(inv_vpn), .hit(inv_hits[e]));
    end

    gh_tlb_first #(.N(ENTRIES), .IW(IW)) u_lk_first (
        .hits(lk_hits), .any(lk_hit), .idx(lk_idx));
    gh_tlb_first #(.N(ENTRIES), .IW(IW)) u_inv_first (
        .hits(inv_hits), .any(inv_any), .idx(inv_idx));

    // Decode invalidate commands gated by this instance's enable.
    always_comb begin
        sext_ok    = (&inv_sext) || !(|inv_sext);
        flush_full = inv_en && inv_all && inv_full;
        flush_part = inv_en && inv_all && !inv_full;
        kill_one   = inv_en && inv_one && !inv_all && sext_ok && inv_any;
    end

    // Pointer priority: full flush, load, read-back, lookup hit.
    always_comb begin
        if (flush_full)             ptr_op = PTR_ZERO;
        else if (ld_en || rd_en)    ptr_op = PTR_STEP;
        else if (lk_req && lk_hit)  ptr_op = PTR_JUMP;
        else                        ptr_op = PTR_HOLD;
    end

    gh_tlb_ptr #(.N(ENTRIES), .IW(IW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(ptr_op), .jump_idx(lk_idx), .ptr(ptr));

    // Current address space number register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_asn <= '0;
        else if (asn_we) cur_asn <= asn_in;
    end

    // Slot valid bits: flushes, loads and single invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else if (flush_full) vld <= '0;
        else if (flush_part) vld <= vld & glb;
        else begin
            if (ld_en)    vld[ptr]     <= 1'b1;
            if (kill_one) vld[inv_idx] <= 1'b0;
        end
    end

    // Slot payload written on load; meaningful only while the slot is valid.
    always_ff @(posedge clk) begin
        if (ld_en && !flush_full && !flush_part) begin
            tagv[ptr]  <= ld_vpn;
            asnv[ptr]  <= cur_asn;
            glb[ptr]   <= ld_pte[GLB_BIT];
            ghv[ptr]   <= ld_pte[GH_LSB +: GH_W];
            pfnv[ptr]  <= ld_pte[PFN_LSB +: PFN_W];
            protv[ptr] <= ld_pte[PROT_W-1:0];
        end
    end

    // Lookup result and read-back view of the slot under the pointer.
    always_comb begin
        lk_pfn  = lk_hit ? pfnv[lk_idx]  : '0;
        lk_prot = lk_hit ? protv[lk_idx] : '0;
        rd_pte  = vld[ptr] ? {pfnv[ptr], ghv[ptr], glb[ptr], protv[ptr]} : '0;
    end

    // R1
    slot_reset_chk: assert property (@(posedge clk) !rst_n |=> (vld == '0));

    // R4
    lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_hits[lk_idx] && ((lk_hits & ~({ENTRIES{1'b1}} << lk_idx)) == '0)));

    // R10
    full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_full |=> (vld == '0));

    // R9
    keep_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_part |=> ((vld & ~glb) == '0));

    // R12
    inv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_en && !ld_en) |=> $stable(vld));
endmodule

// File: tb/tb_gh_tlb.sv
`timescale 1ns/1ps
// Directed bench for gh_tlb: one task per scenario, each checking itself.
module tb_gh_tlb;
    localparam int ENTRIES = 4;
    localparam int VPN_W   = 12;
    localparam int ASN_W   = 4;
    localparam int PFN_W   = 10;
    localparam int PROT_W  = 4;
    localparam int SEXT_W  = 2;
    localparam int PTE_W   = PROT_W + 3 + PFN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0, ld_en = 0, rd_en = 0, asn_we = 0;
    logic inv_en = 0, inv_all = 0, inv_full = 0, inv_one = 0;
    logic [VPN_W-1:0] lk_vpn = '0, ld_vpn = '0, inv_vpn = '0;
    logic [PTE_W-1:0] ld_pte = '0;
    logic [ASN_W-1:0] asn_in = '0;
    logic [SEXT_W-1:0] inv_sext = '0;
    logic lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic [PROT_W-1:0] lk_prot;
    logic [PTE_W-1:0] rd_pte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gh_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W),
             .PROT_W(PROT_W), .SEXT_W(SEXT_W)) dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_prot(lk_prot),
        .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_pte(ld_pte),
        .rd_en(rd_en), .rd_pte(rd_pte), .asn_we(asn_we), .asn_in(asn_in),
        .inv_en(inv_en), .inv_all(inv_all), .inv_full(inv_full),
        .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_sext(inv_sext));

    function automatic logic [PTE_W-1:0] mk(input int pfn, input int gh, input int g, input int prot);
        return {PFN_W'(pfn), 2'(gh), 1'(g), PROT_W'(prot)};
    endfunction

    localparam logic [PTE_W-1:0] PA = {10'h011, 2'd0, 1'b0, 4'h3};
    localparam logic [PTE_W-1:0] PB = {10'h022, 2'd0, 1'b0, 4'h5};
    localparam logic [PTE_W-1:0] PC = {10'h044, 2'd1, 1'b0, 4'h6};
    localparam logic [PTE_W-1:0] PD = {10'h111, 2'd0, 1'b1, 4'h1};

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Drive a lookup address and sample after the combinational settle.
    task automatic probe(input logic [VPN_W-1:0] v);
        @(negedge clk);
        lk_vpn = v;
        #1;
    endtask

    task automatic do_load(input logic [VPN_W-1:0] v, input logic [PTE_W-1:0] p);
        @(negedge clk); ld_en = 1; ld_vpn = v; ld_pte = p;
        @(negedge clk); ld_en = 0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic do_access(input logic [VPN_W-1:0] v);
        @(negedge clk); lk_req = 1; lk_vpn = v;
        @(negedge clk); lk_req = 0;
    endtask

    task automatic do_asn(input logic [ASN_W-1:0] a);
        @(negedge clk); asn_we = 1; asn_in = a;
        @(negedge clk); asn_we = 0;
    endtask

    task automatic do_inv(input logic en, input logic all, input logic full, input logic one,
                          input logic [VPN_W-1:0] v, input logic [SEXT_W-1:0] sx);
        @(negedge clk);
        inv_en = en; inv_all = all; inv_full = full; inv_one = one; inv_vpn = v; inv_sext = sx;
        @(negedge clk);
        inv_en = 0; inv_all = 0; inv_full = 0; inv_one = 0;
    endtask

    task automatic t_reset();
        probe(12'h010);
        chk("R1", "hit after reset", 32'(lk_hit), 0);
        chk("R1", "rd_pte after reset", 32'(rd_pte), 0);
        chk("R2", "pfn on miss", 32'(lk_pfn), 0);
    endtask

    task automatic t_load();
        do_load(12'h010, PA);
        do_load(12'h020, PB);
        do_load(12'h040, PC);
        do_load(12'h100, PD);
        #1;
        chk("R6", "pointer wrapped to slot 0", 32'(rd_pte), 32'(PA));
        probe(12'h010);
        chk("R2", "hit A", 32'(lk_hit), 1);
        chk("R2", "pfn A", 32'(lk_pfn), 32'h011);
        chk("R2", "prot A", 32'(lk_prot), 32'h3);
        probe(12'h020);
        chk("R2", "pfn B", 32'(lk_pfn), 32'h022);
        probe(12'h021);
        chk("R3", "hint 0 exact match", 32'(lk_hit), 0);
    endtask

    task automatic t_hint();
        probe(12'h047);
        chk("R3", "hint 1 covers +7", 32'(lk_pfn), 32'h044);
        probe(12'h048);
        chk("R3", "hint 1 stops at +8", 32'(lk_hit), 0);
    endtask

    task automatic t_nlu();
        do_access(12'h020);
        #1;
        chk("R5", "pointer after hit on slot 1", 32'(rd_pte), 32'(PC));
        do_access(12'h100);
        #1;
        chk("R5", "pointer wraps after hit on last slot", 32'(rd_pte), 32'(PA));
        do_access(12'h300);
        #1;
        chk("R5", "miss keeps pointer", 32'(rd_pte), 32'(PA));
    endtask

    task automatic t_read();
        do_read();
        #1;
        chk("R7", "read-back advances pointer", 32'(rd_pte), 32'(PB));
    endtask

    task automatic t_asn();
        do_asn(4'd5);
        probe(12'h010);
        chk("R8", "private slot misses other ASN", 32'(lk_hit), 0);
        probe(12'h100);
        chk("R8", "global slot hits other ASN", 32'(lk_pfn), 32'h111);
        do_asn(4'd0);
        probe(12'h010);
        chk("R8", "private slot hits own ASN", 32'(lk_pfn), 32'h011);
    endtask

    task automatic t_inv_gate();
        do_inv(0, 1, 1, 0, '0, '0);
        probe(12'h010);
        chk("R12", "disabled flush ignored", 32'(lk_hit), 1);
        do_inv(0, 0, 0, 1, 12'h010, 2'b00);
        probe(12'h010);
        chk("R12", "disabled single invalidate ignored", 32'(lk_hit), 1);
    endtask

    task automatic t_inv_part();
        do_inv(1, 1, 0, 0, '0, '0);
        probe(12'h010);
        chk("R9", "A cleared", 32'(lk_hit), 0);
        probe(12'h044);
        chk("R9", "C cleared", 32'(lk_hit), 0);
        probe(12'h100);
        chk("R9", "global D kept", 32'(lk_pfn), 32'h111);
        chk("R9", "pointer kept at cleared slot 1", 32'(rd_pte), 0);
    endtask

    task automatic t_inv_one();
        do_inv(1, 0, 0, 1, 12'h100, 2'b01);
        probe(12'h100);
        chk("R11", "bad sign extension ignored", 32'(lk_hit), 1);
        do_inv(1, 0, 0, 1, 12'h100, 2'b11);
        probe(12'h100);
        chk("R11", "single invalidate clears D", 32'(lk_hit), 0);
    endtask

    task automatic t_full();
        do_load(12'h050, mk(12'h055, 0, 1, 2));
        do_inv(1, 1, 1, 0, '0, '0);
        probe(12'h050);
        chk("R10", "full flush clears global slot", 32'(lk_hit), 0);
        do_load(12'h200, mk(12'h0AA, 2, 0, 7));
        do_load(12'h205, mk(12'h0BB, 0, 0, 8));
        probe(12'h205);
        chk("R4", "lowest index wins", 32'(lk_pfn), 32'h0AA);
        probe(12'h23F);
        chk("R3", "hint 2 covers +63", 32'(lk_pfn), 32'h0AA);
        probe(12'h240);
        chk("R3", "hint 2 stops at +64", 32'(lk_hit), 0);
        do_access(12'h205);
        #1;
        chk("R10", "flush reset pointer so Y sits in slot 1", 32'(rd_pte), 32'(mk(12'h0BB, 0, 0, 8)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_load();
        t_hint();
        t_nlu();
        t_read();
        t_asn();
        t_inv_gate();
        t_inv_part();
        t_inv_one();
        t_full();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule